// File: doc/BRIEF.md
# Pad-local configuration and signal steering cell

This cell sits beside one bidirectional I/O pad. It keeps a private 13-bit configuration word, fed from a mirrored copy held elsewhere on the chip. It takes a new copy only when a transfer strobe is raised. From that word it drives the pad's static controls: drive mode, input threshold, slew, analog bus hookup, input disable and hold value.

The cell also decides who owns the pad's three live signals: input, output and output enable. They go either to user logic or to the management controller.

An ordinary pad gives the management side a single wire, with one port for each direction. The configuration decides whether that wire acts as an input or as an output. A parameter turns the cell into a fully managed variant, used for test-access and serial-readback pins. That variant gives the management side separate input, output and enable signals and ignores the output-disable bit.

When the pad is set to an input mode with a pull-up or a pull-down, the cell forces the pad's output value locally. The pull direction then works without a dedicated wire.

Top module: `gpio_pad_ctl`

## Requirements
- R1: With `FULL_MGMT=0`, reset (synchronous, active-low) loads word 0x0403. This is mode 001, output-disable=1, management-select=1, all other bits 0. The pad is then undriven (`pad_oe_n_o`=1).
- R2: With `FULL_MGMT=1`, reset loads word 0x1801. This is mode 110, output-disable=0, management-select=1.
- R3: The held word changes only on a rising edge where `xfer_i`=1. At that edge it takes `cfg_mirror_i`, and it is visible on the outputs after that edge.
- R4: The word's bit fields drive the outputs as follows. Bits 12..10 go to `dmode_o`, bit 9 to `trip_sel_o`, bit 8 to `slew_slow_o`, bit 7 to `abus_pol_o`, bit 6 to `abus_sel_o`, bit 5 to `abus_en_o`, bit 4 to `ib_sel_o`, bit 3 to `in_dis_o` and bit 2 to `hold_val_o`. Bit 1 is output-disable and bit 0 is management-select.
- R5: With bit 0 = 0, `pad_out_o` follows `user_out_i` and `user_in_o` follows `pad_in_i`. `pad_oe_n_o` is the inverse of `user_oe_i` when output-disable is 0.
- R6: On an ordinary pad with bit 0 = 1 and output-disable = 1, the shared wire is an input: `mgmt_in_o` follows `pad_in_i`.
- R7: On an ordinary pad with bit 0 = 1 and output-disable = 0, the shared wire is an output. `pad_out_o` follows `mgmt_out_i`, the pad is driven, `mgmt_in_o` is 0, and `mgmt_oe_i` has no effect.
- R8: In mode 010 (pull-up) or mode 011 (pull-down), `pad_out_o` is the inverse of mode bit 10 (1 or 0 respectively), whatever the selected source drives.
- R9: On a `FULL_MGMT=1` pad with bit 0 = 1, `pad_out_o` follows `mgmt_out_i` and `pad_oe_n_o` is the inverse of `mgmt_oe_i`. `mgmt_in_o` follows `pad_in_i`. The output-disable bit has no effect.
- R10: Apart from the R9 case, output-disable = 1 keeps `pad_oe_n_o` at 1.
- R11: With bit 0 = 1, `user_in_o` is 0. With bit 0 = 0, `mgmt_in_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_i | input | 1 | Transfer strobe, loads the mirror word |
| cfg_mirror_i | input | 13 | Mirrored configuration word |
| user_out_i | input | 1 | User output value |
| user_oe_i | input | 1 | User output enable, active-high |
| user_in_o | output | 1 | Pad input to user logic |
| mgmt_out_i | input | 1 | Management output value (shared wire, output role) |
| mgmt_oe_i | input | 1 | Management output enable (fully managed variant only) |
| mgmt_in_o | output | 1 | Pad input to management (shared wire, input role) |
| pad_in_i | input | 1 | Value seen at the pad |
| pad_out_o | output | 1 | Value to drive onto the pad |
| pad_oe_n_o | output | 1 | Pad output enable, active-low |
| dmode_o | output | 3 | Digital drive mode |
| trip_sel_o | output | 1 | Input threshold select |
| slew_slow_o | output | 1 | Slow slew select |
| abus_pol_o | output | 1 | Analog bus polarity |
| abus_sel_o | output | 1 | Analog bus select |
| abus_en_o | output | 1 | Analog bus enable |
| ib_sel_o | output | 1 | Input buffer mode select |
| in_dis_o | output | 1 | Input disable |
| hold_val_o | output | 1 | Holdover value |

## Verification
The output-disable and management-select bits have no static output of their own. Their effect can only be seen through the live signal paths. The hardest case is showing that output-disable is ignored on the fully managed pad while it still blocks the user side on the same pad.

The bench builds one cell of each variant side by side and feeds both the same mirror words. For every word it drives both owners' enables high, then reads the active-low pad enable and the input returns. The pull modes are loaded with the selected source driving the opposite value, so the forced level is visible at the port.

// File: rtl/padctl_pkg.sv
package padctl_pkg;
    localparam int CFG_W = 13;
    localparam int DM_W  = 3;

    typedef struct packed {
        logic [DM_W-1:0] dmode;     // 12..10
        logic            trip_sel;  // 9
        logic            slew_slow; // 8
        logic            abus_pol;  // 7
        logic            abus_sel;  // 6
        logic            abus_en;   // 5
        logic            ib_sel;    // 4
        logic            in_dis;    // 3
        logic            hold_val;  // 2
        logic            out_dis;   // 1
        logic            mgmt_en;   // 0
    } padcfg_t;

    localparam padcfg_t CFG_RST_STD  = padcfg_t'(13'h0403);
    localparam padcfg_t CFG_RST_FULL = padcfg_t'(13'h1801);
    localparam logic [DM_W-2:0] DM_PULL_HI = 2'b01;
endpackage

// File: rtl/padctl_cfg_reg.sv
module padctl_cfg_reg
    import padctl_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    xfer_i,
    input  padcfg_t cfg_i,
    output padcfg_t cfg_o
);
    localparam padcfg_t RST_WORD = FULL_MGMT ? CFG_RST_FULL : CFG_RST_STD;

    typedef struct packed {
        padcfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (xfer_i) begin
            st_d.cfg = cfg_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg <= RST_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
endmodule

// File: rtl/padctl_route.sv
module padctl_route
    import padctl_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  logic [DM_W-1:0] dmode_i,
    input  logic            out_dis_i,
    input  logic            mgmt_en_i,
    input  logic            user_out_i,
    input  logic            user_oe_i,
    input  logic            mgmt_out_i,
    input  logic            mgmt_oe_i,
    input  logic            pad_in_i,
    output logic            pad_out_o,
    output logic            pad_oe_n_o,
    output logic            user_in_o,
    output logic            mgmt_in_o
);
    logic mg_oe_d;
    logic bypass_d;

    generate
        if (FULL_MGMT) begin : g_full
            assign mg_oe_d  = mgmt_oe_i;
            assign bypass_d = mgmt_en_i;
        end else begin : g_std
            assign mg_oe_d  = 1'b1 | mgmt_oe_i;
            assign bypass_d = 1'b0;
        end
    endgenerate

    always_comb begin
        logic src_out_d;
        logic src_oe_d;
        logic pull_d;
        logic drive_d;
        src_out_d = mgmt_en_i ? mgmt_out_i : user_out_i;
        src_oe_d  = mgmt_en_i ? mg_oe_d    : user_oe_i;
        pull_d    = (dmode_i[DM_W-1:1] == DM_PULL_HI);
        pad_out_o = pull_d ? ~dmode_i[0] : src_out_d;
        drive_d   = bypass_d ? src_oe_d : (src_oe_d & ~out_dis_i);
        pad_oe_n_o = ~drive_d;
        user_in_o = mgmt_en_i ? 1'b0 : pad_in_i;
        if (!mgmt_en_i) begin
            mgmt_in_o = 1'b0;
        end else if (bypass_d) begin
            mgmt_in_o = pad_in_i;
        end else begin
            mgmt_in_o = out_dis_i ? pad_in_i : 1'b0;
        end
    end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import padctl_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_i,
    input  logic [CFG_W-1:0] cfg_mirror_i,
    input  logic             user_out_i,
    input  logic             user_oe_i,
    output logic             user_in_o,
    input  logic             mgmt_out_i,
    input  logic             mgmt_oe_i,
    output logic             mgmt_in_o,
    input  logic             pad_in_i,
    output logic             pad_out_o,
    output logic             pad_oe_n_o,
    output logic [DM_W-1:0]  dmode_o,
    output logic             trip_sel_o,
    output logic             slew_slow_o,
    output logic             abus_pol_o,
    output logic             abus_sel_o,
    output logic             abus_en_o,
    output logic             ib_sel_o,
    output logic             in_dis_o,
    output logic             hold_val_o
);
    padcfg_t cfg_q;

    padctl_cfg_reg #(.FULL_MGMT(FULL_MGMT)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .xfer_i(xfer_i),
        .cfg_i (padcfg_t'(cfg_mirror_i)),
        .cfg_o (cfg_q)
    );

    padctl_route #(.FULL_MGMT(FULL_MGMT)) u_route (
        .dmode_i   (cfg_q.dmode),
        .out_dis_i (cfg_q.out_dis),
        .mgmt_en_i (cfg_q.mgmt_en),
        .user_out_i(user_out_i),
        .user_oe_i (user_oe_i),
        .mgmt_out_i(mgmt_out_i),
        .mgmt_oe_i (mgmt_oe_i),
        .pad_in_i  (pad_in_i),
        .pad_out_o (pad_out_o),
        .pad_oe_n_o(pad_oe_n_o),
        .user_in_o (user_in_o),
        .mgmt_in_o (mgmt_in_o)
    );

    assign dmode_o     = cfg_q.dmode;
    assign trip_sel_o  = cfg_q.trip_sel;
    assign slew_slow_o = cfg_q.slew_slow;
    assign abus_pol_o  = cfg_q.abus_pol;
    assign abus_sel_o  = cfg_q.abus_sel;
    assign abus_en_o   = cfg_q.abus_en;
    assign ib_sel_o    = cfg_q.ib_sel;
    assign in_dis_o    = cfg_q.in_dis;
    assign hold_val_o  = cfg_q.hold_val;

    logic [CFG_W-1:0] word_vis;
    assign word_vis = {dmode_o, trip_sel_o, slew_slow_o, abus_pol_o, abus_sel_o,
                       abus_en_o, ib_sel_o, in_dis_o, hold_val_o,
                       cfg_q.out_dis, cfg_q.mgmt_en};

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |=> $stable(word_vis)); // R3
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> (word_vis == $past(cfg_mirror_i))); // R3
    AST_PULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (dmode_o[DM_W-1:1] == DM_PULL_HI) |-> (pad_out_o == ~dmode_o[0])); // R8
    AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.mgmt_en |-> !user_in_o); // R11
    AST_MGMT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.mgmt_en |-> !mgmt_in_o); // R11
    AST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.out_dis && !(FULL_MGMT && cfg_q.mgmt_en)) |-> pad_oe_n_o); // R10
endmodule

// File: tb/sim_gpio_pad_ctl.sv
module sim_gpio_pad_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer = 1'b0;
    logic [12:0] mirror = 13'h0;
    logic uo = 1'b0, uoe = 1'b0, mo = 1'b0, moe = 1'b0, pin = 1'b0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    logic a_uin, a_min, a_pout, a_oen, b_uin, b_min, b_pout, b_oen;
    logic [2:0] a_dm, b_dm;
    logic a_tr, a_sl, a_po, a_se, a_en, a_ib, a_id, a_hv;
    logic b_tr, b_sl, b_po, b_se, b_en, b_ib, b_id, b_hv;

    gpio_pad_ctl #(.FULL_MGMT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .cfg_mirror_i(mirror),
        .user_out_i(uo), .user_oe_i(uoe), .user_in_o(a_uin),
        .mgmt_out_i(mo), .mgmt_oe_i(moe), .mgmt_in_o(a_min),
        .pad_in_i(pin), .pad_out_o(a_pout), .pad_oe_n_o(a_oen),
        .dmode_o(a_dm), .trip_sel_o(a_tr), .slew_slow_o(a_sl), .abus_pol_o(a_po),
        .abus_sel_o(a_se), .abus_en_o(a_en), .ib_sel_o(a_ib), .in_dis_o(a_id),
        .hold_val_o(a_hv));

    gpio_pad_ctl #(.FULL_MGMT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .cfg_mirror_i(mirror),
        .user_out_i(uo), .user_oe_i(uoe), .user_in_o(b_uin),
        .mgmt_out_i(mo), .mgmt_oe_i(moe), .mgmt_in_o(b_min),
        .pad_in_i(pin), .pad_out_o(b_pout), .pad_oe_n_o(b_oen),
        .dmode_o(b_dm), .trip_sel_o(b_tr), .slew_slow_o(b_sl), .abus_pol_o(b_po),
        .abus_sel_o(b_se), .abus_en_o(b_en), .ib_sel_o(b_ib), .in_dis_o(b_id),
        .hold_val_o(b_hv));

    wire [10:0] a_word = {a_dm, a_tr, a_sl, a_po, a_se, a_en, a_ib, a_id, a_hv};
    wire [10:0] b_word = {b_dm, b_tr, b_sl, b_po, b_se, b_en, b_ib, b_id, b_hv};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [12:0] w);
        @(negedge clk);
        mirror = w;
        xfer = 1'b1;
        @(negedge clk);
        xfer = 1'b0;
        #1;
    endtask

    task automatic set_io(input logic u_o, input logic u_e, input logic m_o,
                          input logic m_e, input logic p_i);
        uo = u_o; uoe = u_e; mo = m_o; moe = m_e; pin = p_i;
        #1;
    endtask

    task automatic t_reset();
        set_io(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R1 std word", 16'(a_word), 16'h100);
        check("R1 std undriven", 16'(a_oen), 16'h1);
        check("R2 full word", 16'(b_word), 16'h600);
        check("R2 full driven by mgmt oe", 16'(b_oen), 16'h0);
    endtask

    task automatic t_hold_load();
        @(negedge clk);
        mirror = 13'h1555;
        repeat (3) @(negedge clk);
        #1;
        check("R3 no xfer keeps word", 16'(a_word), 16'h100);
        load(13'h1555);
        check("R3 xfer loads word", 16'(a_word), 16'h1555 >> 2);
        check("R4 dmode field", 16'(a_dm), 16'h5);
        check("R4 trip field", 16'(a_tr), 16'h0);
        check("R4 slew field", 16'(a_sl), 16'h1);
        check("R4 abus sel field", 16'(a_se), 16'h1);
        check("R4 abus pol field", 16'(a_po), 16'h0);
        check("R4 ib field", 16'(b_ib), 16'h1);
        check("R4 hold field", 16'(b_hv), 16'h1);
        load(13'h02A8);
        check("R4 second pattern", 16'({a_tr, a_po, a_en, a_id}), 16'hF);
        check("R4 second pattern zeros", 16'({a_dm, a_sl, a_se, a_ib, a_hv}), 16'h0);
    endtask

    task automatic t_user();
        load(13'h0400);
        set_io(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R5 user out", 16'(a_pout), 16'h1);
        check("R5 user oe", 16'(a_oen), 16'h0);
        check("R5 user in", 16'(a_uin), 16'h1);
        check("R11 mgmt in quiet", 16'(a_min), 16'h0);
        check("R5 full pad user out", 16'(b_pout), 16'h1);
        set_io(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R5 user oe low", 16'(a_oen), 16'h1);
        check("R5 user out low", 16'(a_pout), 16'h0);
        check("R5 user in low", 16'(a_uin), 16'h0);
        load(13'h0402);
        set_io(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R10 user blocked std", 16'(a_oen), 16'h1);
        check("R10 user blocked full", 16'(b_oen), 16'h1);
    endtask

    task automatic t_mgmt_in();
        load(13'h0403);
        set_io(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R6 mgmt in high", 16'(a_min), 16'h1);
        check("R10 std undriven", 16'(a_oen), 16'h1);
        check("R11 user in quiet", 16'(a_uin), 16'h0);
        set_io(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R6 mgmt in low", 16'(a_min), 16'h0);
    endtask

    task automatic t_mgmt_out();
        load(13'h0401);
        set_io(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R7 mgmt out high", 16'(a_pout), 16'h1);
        check("R7 driven despite mgmt oe low", 16'(a_oen), 16'h0);
        check("R7 mgmt in quiet", 16'(a_min), 16'h0);
        check("R9 full oe follows mgmt", 16'(b_oen), 16'h1);
        set_io(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R7 mgmt out low", 16'(a_pout), 16'h0);
    endtask

    task automatic t_full();
        load(13'h0403);
        set_io(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R9 full drives despite disable", 16'(b_oen), 16'h0);
        check("R9 full out", 16'(b_pout), 16'h1);
        check("R9 full mgmt in", 16'(b_min), 16'h1);
        set_io(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 full oe off", 16'(b_oen), 16'h1);
        check("R9 full mgmt in low", 16'(b_min), 16'h0);
    endtask

    task automatic t_pull();
        load(13'h0803);
        set_io(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 pull-up forces 1", 16'(a_pout), 16'h1);
        load(13'h0C03);
        set_io(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R8 pull-down forces 0", 16'(a_pout), 16'h0);
        check("R8 pull-down full", 16'(b_pout), 16'h0);
        load(13'h0800);
        set_io(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 pull-up user side", 16'(a_pout), 16'h1);
    endtask

    task automatic t_rereset();
        load(13'h1FFC);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset restores std", 16'(a_word), 16'h100);
        check("R2 reset restores full", 16'(b_word), 16'h600);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_hold_load();
        t_user();
        t_mgmt_in();
        t_mgmt_out();
        t_full();
        t_pull();
        t_rereset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule